// File: doc/BRIEF.md
# Mailbox-Commanded Isolated I/O Controller

This block is the device side of a small isolated I/O card. A host reaches it over a byte-wide register bus. Through that bus it can load three outgoing mailbox bytes and read four incoming mailbox bytes. Two of the outgoing bytes hold arguments. A write to the third byte, the command slot, runs one command in the next clock edge. The block then copies the command code into incoming byte 2. The host polls that byte and treats a match with the code it sent as completion.

The commands control eight relay outputs and report their state. They also sample the eight isolated inputs and manage eight 16-bit up-counters, one for each input. Each counter has its own enable, count edge, reset value and match value. It also has a sticky match flag. The inputs pass through a multi-flop synchronizer before edge detection.

Every register write takes one cycle, so the bus needs no handshake. A mailbox read is a combinational select of the incoming byte addressed by the host.

Top module: `mbox_io_ctrl`

## Requirements
- R1: After reset, the relays are off and all four incoming bytes read 0x00. All counters are at 0x0000, disabled, set to count rising edges, with reset value 0x0000, match value 0x8000 and their match flags clear.
- R2: Writing code C to address 2 makes incoming byte 2 equal C from the cycle after the write, except that code 0x00 leaves it 0x00.
- R3: Code 0x00 clears incoming byte 2 and copies the synchronized input levels into incoming byte 3, with input i at bit i.
- R4: Code 0x01 drives relay_out from outgoing byte 0. Code 0x02 copies the relay state into incoming byte 0. Relays change on no other command.
- R5: Code 0x28 loads the enable mask from outgoing byte 0, where bit i enables counter i. A counter with its bit clear does not count.
- R6: Code 0x2C loads the edge mask from outgoing byte 0. For each input, bit i = 0 counts rising edges and bit i = 1 counts falling edges.
- R7: Code 0x40+n sets the reset value of counter n to {byte1, byte0}. Code 0x29 loads every counter whose bit is set in outgoing byte 0 with its reset value and clears that counter's match flag.
- R8: Code 0x2F places counter number byte0[2:0] in the incoming bytes, with bits 15:8 in byte 1 and bits 7:0 in byte 0.
- R9: Code 0x48+n sets the match value of counter n to {byte1, byte0}. match_flag[n] sets whenever the count equals the match value. Only 0x29 or reset clears it.
- R10: A counter at 0xFFFF that counts one more edge goes to 0x0000.
- R11: A code outside 0x00–0x02, 0x28, 0x29, 0x2C, 0x2F and 0x40–0x4F is echoed into incoming byte 2 and changes no relay, counter or other incoming byte.
- R12: Writes to address 0, 1 or 3 run no command and leave the incoming bytes unchanged. rd_addr k returns incoming byte k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one byte per cycle |
| wr_addr | input | 2 | Outgoing byte index; 2 is the command slot |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Incoming byte index |
| rd_data | output | 8 | Selected incoming byte |
| iso_in | input | NUM_CH | Asynchronous isolated inputs |
| relay_out | output | 8 | Relay drive |
| match_flag | output | NUM_CH | Sticky per-counter match flags |

## Verification
The bench builds the block with its defaults: NUM_CH = 8 and SYNC_STAGES = 2. With those values every 3-bit counter index in the readback command selects a real counter. All eight enable and edge bits are live, so random masks exercise mixed rising and falling counting together. Directed cases place a reset value just below 0xFFFF so that the wrap and a match at zero are reached within a few input pulses.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int CNT_W = 16;
  localparam int SLOTS = 8;

  localparam logic [7:0] OP_CLEAR     = 8'h00;
  localparam logic [7:0] OP_RELAY_SET = 8'h01;
  localparam logic [7:0] OP_RELAY_GET = 8'h02;
  localparam logic [7:0] OP_CNT_EN    = 8'h28;
  localparam logic [7:0] OP_CNT_LOAD  = 8'h29;
  localparam logic [7:0] OP_CNT_EDGE  = 8'h2C;
  localparam logic [7:0] OP_CNT_READ  = 8'h2F;
  localparam logic [4:0] OP_RV_HI     = 5'b01000; // 0x40..0x47
  localparam logic [4:0] OP_MV_HI     = 5'b01001; // 0x48..0x4F

  typedef struct packed {
    logic       clr;
    logic       set_relay;
    logic       get_relay;
    logic       set_en;
    logic       load;
    logic       set_edge;
    logic       get_cnt;
    logic       set_rv;
    logic       set_mv;
    logic [2:0] chan;
  } cmd_ctl_t;
endpackage

// File: rtl/mbox_edge_sync.sv
module mbox_edge_sync #(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] async_in,
  input  logic [NUM_CH-1:0] fall_sel,
  output logic [NUM_CH-1:0] level,
  output logic [NUM_CH-1:0] event_o
);
  logic [NUM_CH-1:0] prev_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], async_in[i]};
    end
    assign level[i] = chain_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      event_o[i] = fall_sel[i] ? (prev_q[i] & ~level[i]) : (level[i] & ~prev_q[i]);
  end
endmodule

// File: rtl/mbox_chan_counter.sv
module mbox_chan_counter
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_ev,
  input  logic             load,
  input  logic             wr_rv,
  input  logic             wr_mv,
  input  logic [CNT_W-1:0] wval,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] rv_q, mv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      rv_q <= '0;
      mv_q <= CNT_W'(16'h8000);
      hit  <= 1'b0;
    end else begin
      if (wr_rv) rv_q <= wval;
      if (wr_mv) mv_q <= wval;
      if (load) begin
        cnt <= rv_q;
        hit <= 1'b0;
      end else begin
        if (count_ev)     cnt <= cnt + 1'b1;
        if (cnt == mv_q)  hit <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbox_cmd_decode.sv
module mbox_cmd_decode
  import mbox_pkg::*;
(
  input  logic [7:0] code,
  output cmd_ctl_t   ctl
);
  always_comb begin
    ctl      = '0;
    ctl.chan = code[2:0];
    case (code)
      OP_CLEAR:     ctl.clr       = 1'b1;
      OP_RELAY_SET: ctl.set_relay = 1'b1;
      OP_RELAY_GET: ctl.get_relay = 1'b1;
      OP_CNT_EN:    ctl.set_en    = 1'b1;
      OP_CNT_LOAD:  ctl.load      = 1'b1;
      OP_CNT_EDGE:  ctl.set_edge  = 1'b1;
      OP_CNT_READ:  ctl.get_cnt   = 1'b1;
      default: begin
        ctl.set_rv = (code[7:3] == OP_RV_HI);
        ctl.set_mv = (code[7:3] == OP_MV_HI);
      end
    endcase
  end
endmodule

// File: rtl/mbox_io_ctrl.sv
module mbox_io_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic [NUM_CH-1:0] iso_in,
  output logic [7:0]        relay_out,
  output logic [NUM_CH-1:0] match_flag
);
  logic [7:0] arg0_q, arg1_q;
  logic [7:0] in0_q, in1_q, in2_q, in3_q;
  logic [NUM_CH-1:0] en_q, fall_q, lvl, evt;
  logic [7:0] lvl8;
  logic cmd_fire;
  cmd_ctl_t ctl;
  logic [CNT_W-1:0] cnt_arr [SLOTS];

  assign cmd_fire = wr_en && (wr_addr == 2'd2);

  mbox_cmd_decode u_dec (.code(wr_data), .ctl(ctl));

  mbox_edge_sync #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(iso_in), .fall_sel(fall_q),
    .level(lvl), .event_o(evt)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NUM_CH) begin : g_cnt
      mbox_chan_counter u_cnt (
        .clk(clk), .rst_n(rst_n),
        .count_ev(en_q[i] & evt[i]),
        .load(cmd_fire & ctl.load & arg0_q[i]),
        .wr_rv(cmd_fire & ctl.set_rv & (ctl.chan == 3'(i))),
        .wr_mv(cmd_fire & ctl.set_mv & (ctl.chan == 3'(i))),
        .wval({arg1_q, arg0_q}),
        .cnt(cnt_arr[i]),
        .hit(match_flag[i])
      );
    end else begin : g_none
      assign cnt_arr[i] = '0;
    end
  end

  always_comb begin
    lvl8 = '0;
    lvl8[NUM_CH-1:0] = lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg0_q <= '0; arg1_q <= '0;
      in0_q <= '0; in1_q <= '0; in2_q <= '0; in3_q <= '0;
      relay_out <= '0; en_q <= '0; fall_q <= '0;
    end else begin
      if (wr_en && wr_addr == 2'd0) arg0_q <= wr_data;
      if (wr_en && wr_addr == 2'd1) arg1_q <= wr_data;
      if (cmd_fire) begin
        in2_q <= wr_data;
        if (ctl.clr)       in3_q     <= lvl8;
        if (ctl.set_relay) relay_out <= arg0_q;
        if (ctl.get_relay) in0_q     <= relay_out;
        if (ctl.set_en)    en_q      <= arg0_q[NUM_CH-1:0];
        if (ctl.set_edge)  fall_q    <= arg0_q[NUM_CH-1:0];
        if (ctl.get_cnt)   {in1_q, in0_q} <= cnt_arr[arg0_q[2:0]];
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = in0_q;
      2'd1:    rd_data = in1_q;
      2'd2:    rd_data = in2_q;
      default: rd_data = in3_q;
    endcase
  end
endmodule

// File: rtl/mbox_io_ctrl_chk.sv
module mbox_io_ctrl_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [7:0]        wr_data,
  input logic [7:0]        relay_out,
  input logic [NUM_CH-1:0] match_flag,
  input logic [7:0]        ib0,
  input logic [7:0]        ib1,
  input logic [7:0]        ib2,
  input logic [7:0]        ib3
);
  logic fire, known;
  assign fire  = wr_en && (wr_addr == 2'd2);
  assign known = (wr_data <= 8'h02) || (wr_data == 8'h28) || (wr_data == 8'h29) ||
                 (wr_data == 8'h2C) || (wr_data == 8'h2F) || (wr_data[7:4] == 4'h4);

  AST_ECHO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ib2 == $past(wr_data)); // R2
  AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_data == 8'h00) |=> ib2 == 8'h00); // R3
  AST_RELAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && wr_data == 8'h01) |=> $stable(relay_out)); // R4
  AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && wr_data == 8'h29) |=> ((match_flag & $past(match_flag)) == $past(match_flag))); // R9
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !known) |=> ($stable(relay_out) && $stable(ib0) && $stable(ib1) && $stable(ib3))); // R11
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(ib0) && $stable(ib1) && $stable(ib2) && $stable(ib3))); // R12
endmodule

bind mbox_io_ctrl mbox_io_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .relay_out(relay_out), .match_flag(match_flag),
  .ib0(in0_q), .ib1(in1_q), .ib2(in2_q), .ib3(in3_q)
);

// File: tb/sim_mbox_io_ctrl.sv
module sim_mbox_io_ctrl;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data, relay_out;
  logic [7:0] iso_in = 0, match_flag;
  int n_chk = 0, n_fail = 0;

  logic [15:0] m_cnt [8];
  logic [15:0] m_rv [8];
  logic [15:0] m_mv [8];
  logic [7:0]  m_en = 0, m_edge = 0, m_flag = 0, m_in = 0;

  always #5 clk = ~clk;

  mbox_io_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .iso_in(iso_in),
    .relay_out(relay_out), .match_flag(match_flag));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic cmd(logic [7:0] code, logic [7:0] b0, logic [7:0] b1);
    wr(2'd0, b0); wr(2'd1, b1); wr(2'd2, code);
  endtask

  function automatic void model_eval();
    for (int i = 0; i < 8; i++) if (m_cnt[i] == m_mv[i]) m_flag[i] = 1'b1;
  endfunction

  task automatic drive_in(logic [7:0] v);
    for (int i = 0; i < 8; i++)
      if (m_en[i] && (m_edge[i] ? (m_in[i] && !v[i]) : (!m_in[i] && v[i])))
        m_cnt[i] = m_cnt[i] + 16'd1;
    m_in = v;
    model_eval();
    @(negedge clk); iso_in = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic set_en(logic [7:0] m);   cmd(8'h28, m, 8'h00); m_en = m;   endtask
  task automatic set_edge(logic [7:0] m); cmd(8'h2C, m, 8'h00); m_edge = m; endtask
  task automatic set_rv(int ch, logic [15:0] v);
    cmd(8'h40 + 8'(ch), v[7:0], v[15:8]); m_rv[ch] = v;
  endtask
  task automatic set_mv(int ch, logic [15:0] v);
    cmd(8'h48 + 8'(ch), v[7:0], v[15:8]); m_mv[ch] = v; model_eval();
    repeat (2) @(negedge clk);
  endtask
  task automatic load(logic [7:0] m);
    cmd(8'h29, m, 8'h00);
    for (int i = 0; i < 8; i++) if (m[i]) begin m_cnt[i] = m_rv[i]; m_flag[i] = 1'b0; end
    model_eval();
    repeat (2) @(negedge clk);
  endtask
  task automatic read_cnt(int ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    cmd(8'h2F, 8'(ch), 8'h00);
    rd(2'd0, lo); rd(2'd1, hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b, b2, b3;
    logic [15:0] v;
    void'($urandom(32'd7321));
    for (int i = 0; i < 8; i++) begin m_cnt[i] = 0; m_rv[i] = 0; m_mv[i] = 16'h8000; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 relay", relay_out, 8'h00);
    check("R1 match", match_flag, 8'h00);
    for (int k = 0; k < 4; k++) begin rd(2'(k), b); check("R1 incoming", b, 8'h00); end
    read_cnt(5, v); check("R1 R8 count", v, 16'h0000);
    rd(2'd2, b); check("R2 echo 2F", b, 8'h2F);

    // R4 relays
    cmd(8'h01, 8'hA5, 8'h00); check("R4 relay drive", relay_out, 8'hA5);
    rd(2'd2, b); check("R2 echo 01", b, 8'h01);
    cmd(8'h02, 8'h00, 8'h00); rd(2'd0, b); check("R4 relay read", b, 8'hA5);

    // R3 input snapshot
    drive_in(8'h3C);
    cmd(8'h00, 8'h00, 8'h00);
    rd(2'd3, b); check("R3 inputs", b, 8'h3C);
    rd(2'd2, b); check("R3 cleared", b, 8'h00);

    // R11 unknown code
    cmd(8'h02, 8'h00, 8'h00);
    cmd(8'h77, 8'h5A, 8'h00);
    rd(2'd2, b); check("R11 echo", b, 8'h77);
    rd(2'd0, b); check("R11 byte0 kept", b, 8'hA5);
    rd(2'd3, b); check("R11 byte3 kept", b, 8'h3C);
    check("R11 relay kept", relay_out, 8'hA5);

    // R12 non-command writes
    wr(2'd0, 8'h11); wr(2'd1, 8'h22); wr(2'd3, 8'h2F);
    rd(2'd2, b); rd(2'd0, b2); rd(2'd3, b3);
    check("R12 byte2 kept", b, 8'h77);
    check("R12 byte0 kept", b2, 8'hA5);
    check("R12 byte3 kept", b3, 8'h3C);
    drive_in(8'h00);

    // R5 disabled counters ignore edges
    drive_in(8'hFF); drive_in(8'h00);
    read_cnt(2, v); check("R5 disabled", v, 16'h0000);

    // R6 rising vs falling
    set_en(8'h03); set_edge(8'h02);
    drive_in(8'h03);
    read_cnt(0, v); check("R6 rising ch0", v, 16'h0001);
    read_cnt(1, v); check("R6 falling ch1 before fall", v, 16'h0000);
    drive_in(8'h00);
    read_cnt(1, v); check("R6 falling ch1", v, 16'h0001);

    // R7 R10 R9 reload, wrap and sticky match
    set_rv(3, 16'hFFFE); load(8'h08);
    read_cnt(3, v); check("R7 loaded", v, 16'hFFFE);
    set_mv(3, 16'h0000); set_en(8'h0B); set_edge(8'h02);
    drive_in(8'h08); drive_in(8'h00); drive_in(8'h08); drive_in(8'h00);
    read_cnt(3, v); check("R10 wrap", v, 16'h0000);
    drive_in(8'h08); drive_in(8'h00);
    read_cnt(3, v); check("R10 after wrap", v, 16'h0001);
    check("R9 sticky flag", match_flag[3], 1'b1);
    load(8'h08); check("R7 flag cleared by load", match_flag[3], 1'b0);

    // Random rounds
    for (int r = 0; r < 8; r++) begin
      set_en(8'($urandom)); set_edge(8'($urandom));
      for (int c = 0; c < 8; c++) begin
        if ($urandom % 2) set_rv(c, 16'($urandom));
        if ($urandom % 2) set_mv(c, m_rv[c] + 16'($urandom % 4));
      end
      load(8'($urandom));
      for (int s = 0; s < 12; s++) drive_in(8'($urandom));
      for (int c = 0; c < 8; c++) begin
        read_cnt(c, v); check("R8 R5 R6 random count", v, m_cnt[c]);
      end
      check("R9 random flags", match_flag, m_flag);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule